// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine for a multicycle processor datapath. In that datapath one ALU, one memory port and one register file are shared across several clock cycles per instruction. The sequencer reads the 6-bit opcode field held in the instruction register. It steps through ten states and drives every datapath select and write enable from the current state alone, so it is a Moore machine.

Every instruction starts with a common fetch step and a common decode step. The decode step also computes a branch target in advance. After decode the machine dispatches on the opcode to a short tail of one to three states for that instruction class, so instructions take 3 to 5 cycles. An opcode the sequencer does not know sends it straight back to fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_n is low the state is 0 and the outputs carry the fetch values. The state output is the binary state number, 0 to 9.
- R2: State 0 asserts mem_read, ir_load and pc_load, with addr_from_alu=0, alu_a_reg=0, alu_b_sel=01, alu_mode=00 and pc_next_sel=00. The next state is always 1.
- R3: State 1 drives alu_a_reg=0, alu_b_sel=11 and alu_mode=00, with every write enable at 0. It dispatches on the opcode: 100011 (load) or 101011 (store) goes to 2, 000000 (register op) goes to 6, 000100 (branch-if-equal) goes to 8, and 000010 (jump) goes to 9.
- R4: Any other opcode seen in state 1 sends the machine to state 0 on the next cycle.
- R5: State 2 drives alu_a_reg=1, alu_b_sel=10 and alu_mode=00. The store opcode goes to state 5; every other opcode goes to state 3.
- R6: State 3 asserts mem_read with addr_from_alu=1 and goes to 4. State 4 asserts rf_write with rf_dest_rd=0 and wb_from_mem=1, then goes to 0.
- R7: State 5 asserts mem_write with addr_from_alu=1, then goes to 0.
- R8: State 6 drives alu_a_reg=1, alu_b_sel=00 and alu_mode=10, then goes to 7. State 7 asserts rf_write with rf_dest_rd=1 and wb_from_mem=0, then goes to 0.
- R9: State 8 drives alu_a_reg=1, alu_b_sel=00 and alu_mode=01, and asserts pc_load_if_zero with pc_next_sel=01. It then goes to 0.
- R10: State 9 asserts pc_load with pc_next_sel=10, then goes to 0.
- R11: With the opcode held, the cycles from one entry to state 0 to the next are: load 5, store 4, register op 4, branch 3, jump 3, and unknown opcode 2.
- R12: In each state every write enable not listed for it is 0: pc_load, pc_load_if_zero, mem_read, mem_write, ir_load and rf_write. Every select not listed for a state is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_if_zero | output | 1 | Program counter write when the ALU zero flag is set |
| addr_from_alu | output | 1 | Memory address from the ALU result register (1) or the program counter (0) |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| wb_from_mem | output | 1 | Register write data from the memory data register (1) or the ALU result (0) |
| ir_load | output | 1 | Instruction register write |
| pc_next_sel | output | 2 | Program counter source: 00 increment, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| alu_a_reg | output | 1 | ALU operand A from register A (1) or the program counter (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| rf_write | output | 1 | Register file write enable |
| rf_dest_rd | output | 1 | Destination register from the rd field (1) or the rt field (0) |
| state | output | 4 | Current state number |

## Verification
The hardest cases to reach are those where the opcode changes while an instruction is in flight. One such case is a store arriving only in state 2. Another is an unknown code arriving exactly in the decode cycle. A front end that holds the opcode steady never produces either. The bench first runs each instruction class with the opcode held, to measure the cycle counts. It then drives a new opcode on every cycle, drawn from a pseudo-random sequence that mixes the five known codes with unknown ones. This drives decode and the address state with every kind of code, and a behavioural model is compared on each clock.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int STEP_W = 4;
  localparam int OPC_W  = 6;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MREAD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MWRITE = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_e;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [1:0] {
    B_REG   = 2'b00,
    B_FOUR  = 2'b01,
    B_IMM   = 2'b10,
    B_IMMSH = 2'b11
  } bsel_e;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_FUNCT = 2'b10
  } amode_e;

  typedef enum logic [1:0] {
    PC_INC  = 2'b00,
    PC_ALUQ = 2'b01,
    PC_JMP  = 2'b10
  } pcsel_e;

  typedef struct packed {
    logic   pc_load;
    logic   pc_load_if_zero;
    logic   addr_from_alu;
    logic   mem_read;
    logic   mem_write;
    logic   wb_from_mem;
    logic   ir_load;
    pcsel_e pc_next_sel;
    amode_e alu_mode;
    logic   alu_a_reg;
    bsel_e  alu_b_sel;
    logic   rf_write;
    logic   rf_dest_rd;
  } ctrl_t;

  // Opcode classification used by the dispatch in the decode state
  function automatic logic opc_known(input logic [OPC_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_RTYPE) ||
           (op == OPC_BEQ)  || (op == OPC_JUMP);
  endfunction

  function automatic step_e decode_target(input logic [OPC_W-1:0] op);
    step_e t;
    unique case (op)
      OPC_LOAD, OPC_STORE: t = ST_MADDR;
      OPC_RTYPE:           t = ST_EXEC;
      OPC_BEQ:             t = ST_BRANCH;
      OPC_JUMP:            t = ST_JUMP;
      default:             t = ST_FETCH;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = OPC_W
) (
  input  step_e           cur,
  input  logic [OP_W-1:0] opcode,
  output step_e           nxt,
  output logic            bad_op_evt
);

  always_comb begin
    bad_op_evt = 1'b0;
    nxt        = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        nxt        = decode_target(opcode);
        bad_op_evt = !opc_known(opcode);
      end
      ST_MADDR:  nxt = (opcode == OPC_STORE) ? ST_MWRITE : ST_MREAD;
      ST_MREAD:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      ST_LDWB, ST_MWRITE, ST_RWB, ST_BRANCH, ST_JUMP: nxt = ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_streg.sv
module mc_ctrl_streg
  import mc_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_e nxt,
  output step_e cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= ST_FETCH;
    else        cur <= nxt;
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  step_e cur,
  output ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctrl.mem_read  = 1'b1;
        ctrl.ir_load   = 1'b1;
        ctrl.alu_b_sel = B_FOUR;
        ctrl.alu_mode  = ALU_ADD;
        ctrl.pc_load   = 1'b1;
        ctrl.pc_next_sel = PC_INC;
      end
      ST_DECODE: begin
        ctrl.alu_b_sel = B_IMMSH;
        ctrl.alu_mode  = ALU_ADD;
      end
      ST_MADDR: begin
        ctrl.alu_a_reg = 1'b1;
        ctrl.alu_b_sel = B_IMM;
        ctrl.alu_mode  = ALU_ADD;
      end
      ST_MREAD: begin
        ctrl.mem_read      = 1'b1;
        ctrl.addr_from_alu = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_write    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      ST_MWRITE: begin
        ctrl.mem_write     = 1'b1;
        ctrl.addr_from_alu = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a_reg = 1'b1;
        ctrl.alu_b_sel = B_REG;
        ctrl.alu_mode  = ALU_FUNCT;
      end
      ST_RWB: begin
        ctrl.rf_write   = 1'b1;
        ctrl.rf_dest_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_a_reg       = 1'b1;
        ctrl.alu_b_sel       = B_REG;
        ctrl.alu_mode        = ALU_SUB;
        ctrl.pc_load_if_zero = 1'b1;
        ctrl.pc_next_sel     = PC_ALUQ;
      end
      ST_JUMP: begin
        ctrl.pc_load     = 1'b1;
        ctrl.pc_next_sel = PC_JMP;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = OPC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_load,
  output logic            pc_load_if_zero,
  output logic            addr_from_alu,
  output logic            mem_read,
  output logic            mem_write,
  output logic            wb_from_mem,
  output logic            ir_load,
  output logic [1:0]      pc_next_sel,
  output logic [1:0]      alu_mode,
  output logic            alu_a_reg,
  output logic [1:0]      alu_b_sel,
  output logic            rf_write,
  output logic            rf_dest_rd,
  output logic [STEP_W-1:0] state
);

  step_e cur_step;
  step_e nxt_step;
  ctrl_t ctrl;
  logic  bad_op_evt;

  mc_ctrl_next #(.OP_W(OP_W)) u_next (
    .cur        (cur_step),
    .opcode     (opcode),
    .nxt        (nxt_step),
    .bad_op_evt (bad_op_evt)
  );

  mc_ctrl_streg u_streg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt_step),
    .cur   (cur_step)
  );

  mc_ctrl_decode u_decode (
    .cur  (cur_step),
    .ctrl (ctrl)
  );

  assign pc_load         = ctrl.pc_load;
  assign pc_load_if_zero = ctrl.pc_load_if_zero;
  assign addr_from_alu   = ctrl.addr_from_alu;
  assign mem_read        = ctrl.mem_read;
  assign mem_write       = ctrl.mem_write;
  assign wb_from_mem     = ctrl.wb_from_mem;
  assign ir_load         = ctrl.ir_load;
  assign pc_next_sel     = ctrl.pc_next_sel;
  assign alu_mode        = ctrl.alu_mode;
  assign alu_a_reg       = ctrl.alu_a_reg;
  assign alu_b_sel       = ctrl.alu_b_sel;
  assign rf_write        = ctrl.rf_write;
  assign rf_dest_rd      = ctrl.rf_dest_rd;
  assign state           = cur_step;

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mc_ctrl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] step,
  input logic [5:0] opcode,
  input logic       pc_load,
  input logic       mem_read,
  input logic       mem_write,
  input logic       ir_load,
  input logic       rf_write,
  input logic       bad_op_evt
);

  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 4'd9);

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == 4'd0 |=> step == 4'd1);

  // R3
  load_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd1 && opcode == OPC_LOAD) |=> step == 4'd2);

  // R4
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op_evt |=> step == 4'd0);

  // R11
  tail_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd4 || step == 4'd5 || step == 4'd7 || step == 4'd8 || step == 4'd9)
      |=> step == 4'd0);

  // R12
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write));

  // R12
  pc_load_where_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (step == 4'd0 || step == 4'd9));

  // R12
  rf_write_where_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_write |-> (step == 4'd4 || step == 4'd7) && !ir_load);

endmodule

bind mc_ctrl_fsm mc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step       (state),
  .opcode     (opcode),
  .pc_load    (pc_load),
  .mem_read   (mem_read),
  .mem_write  (mem_write),
  .ir_load    (ir_load),
  .rf_write   (rf_write),
  .bad_op_evt (bad_op_evt)
);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic pc_load, pc_load_if_zero, addr_from_alu, mem_read, mem_write;
  logic wb_from_mem, ir_load, alu_a_reg, rf_write, rf_dest_rd;
  logic [1:0] pc_next_sel, alu_mode, alu_b_sel;
  logic [3:0] state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ref_st = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .addr_from_alu(addr_from_alu), .mem_read(mem_read), .mem_write(mem_write),
    .wb_from_mem(wb_from_mem), .ir_load(ir_load), .pc_next_sel(pc_next_sel),
    .alu_mode(alu_mode), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
    .rf_write(rf_write), .rf_dest_rd(rf_dest_rd), .state(state)
  );

  // Reference: next state from the requirement text
  function automatic int ref_next(input int s, input logic [5:0] op);
    if (s == 0) return 1;
    if (s == 1) begin
      if (op == 6'b100011 || op == 6'b101011) return 2;
      if (op == 6'b000000) return 6;
      if (op == 6'b000100) return 8;
      if (op == 6'b000010) return 9;
      return 0;
    end
    if (s == 2) return (op == 6'b101011) ? 5 : 3;
    if (s == 3) return 4;
    if (s == 6) return 7;
    return 0;
  endfunction

  // Expected outputs, packed in port order pc_load .. rf_dest_rd
  function automatic logic [15:0] ref_out(input int s);
    logic pl = 0, plz = 0, adr = 0, mr = 0, mw = 0, wbm = 0, irl = 0, aa = 0, rw = 0, rd = 0;
    logic [1:0] ps = 0, am = 0, bs = 0;
    case (s)
      0: begin mr = 1; irl = 1; pl = 1; bs = 2'b01; end
      1: bs = 2'b11;
      2: begin aa = 1; bs = 2'b10; end
      3: begin mr = 1; adr = 1; end
      4: begin rw = 1; wbm = 1; end
      5: begin mw = 1; adr = 1; end
      6: begin aa = 1; am = 2'b10; end
      7: begin rw = 1; rd = 1; end
      8: begin aa = 1; am = 2'b01; plz = 1; ps = 2'b01; end
      9: begin pl = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pl, plz, adr, mr, mw, wbm, irl, ps, am, aa, bs, rw, rd};
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] dut_out();
    return {pc_load, pc_load_if_zero, addr_from_alu, mem_read, mem_write, wb_from_mem,
            ir_load, pc_next_sel, alu_mode, alu_a_reg, alu_b_sel, rf_write, rf_dest_rd};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_st <= 0;
    else        ref_st <= ref_next(ref_st, opcode);
  end

  // Per-cycle comparison against the model (outputs and state, R12 covers the zeros)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (state !== 4'(ref_st) || dut_out() !== ref_out(ref_st)) begin
        errors++;
        $display("FAIL %s/R12 state=%0d ctrl=%b expected state=%0d ctrl=%b",
                 req_of(ref_st), state, dut_out(), ref_st, ref_out(ref_st));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_instr(input logic [5:0] op, input int exp, input string tag);
    int n = 0;
    opcode = op;
    do begin
      @(negedge clk);
      n++;
    end while (state !== 4'd0);
    checks++;
    if (n != exp) begin
      errors++;
      $display("FAIL %s opcode=%b cycles=%0d expected %0d", tag, op, n, exp);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    opcode = 6'b100011;
    repeat (3) @(negedge clk);
    // R1: reset holds fetch
    checks++;
    if (state !== 4'd0 || dut_out() !== ref_out(0)) begin
      errors++;
      $display("FAIL R1 state=%0d ctrl=%b expected state=0 ctrl=%b", state, dut_out(), ref_out(0));
    end
    rst_n = 1'b1;
    @(negedge clk);
    // now in state 1 after one edge; wait for fetch
    while (state !== 4'd0) @(negedge clk);
    // R11 cycle counts with opcode held
    run_instr(6'b100011, 5, "R11 load");
    run_instr(6'b101011, 4, "R11 store");
    run_instr(6'b000000, 4, "R11 reg-op");
    run_instr(6'b000100, 3, "R11 branch");
    run_instr(6'b000010, 3, "R11 jump");
    run_instr(6'b111111, 2, "R4 unknown");
    run_instr(6'b000001, 2, "R4 unknown");
    run_instr(6'b100011, 5, "R11 load again");
    // Opcode changing every cycle, mixed known and unknown codes
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0: opcode = 6'b100011;
        3'd1: opcode = 6'b101011;
        3'd2: opcode = 6'b000000;
        3'd3: opcode = 6'b000100;
        3'd4: opcode = 6'b000010;
        default: opcode = lfsr[10:5];
      endcase
      @(negedge clk);
    end
    // Reset mid-instruction returns to fetch (R1)
    opcode = 6'b000000;
    while (state !== 4'd6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (state !== 4'd0 || dut_out() !== ref_out(0)) begin
      errors++;
      $display("FAIL R1 async state=%0d expected 0", state);
    end
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule